// File: doc/BRIEF.md
# Privileged Special-Register Access Unit

This block sits beside the execute stage of a 32-bit RISC core and serves the core's move-to-special-register and move-from-special-register operations. Each request carries a 16-bit register address, write data, a write flag, the old value of the destination general register and the processor's current supervisor flag. The address is split into a 5-bit group (bits 15:11) and an 11-bit number within the group (bits 10:0). The block decodes this address and checks the access right. It then updates one of its own held registers, or returns read data one cycle later. An access the current mode may not make produces a one-cycle illegal-instruction pulse instead.

The block holds the exception vector base, the saved exception PC, the saved effective address, the saved exception status, a 64-bit multiply-accumulate register reached as two 32-bit halves, and a parameterised bank of shadow general registers. It also answers reads of a set of fixed configuration words. A write to the next-PC register that changes the PC produces a redirect request toward the fetch unit. The floating-point status word, the translation arrays, the programmable interrupt controller and the tick timer live elsewhere. The block only raises a select strobe toward them in the request cycle, and it returns their `extRdata` as read data.

Top module: `sprAccessUnit`

## Requirements
- R1: While `rstN` is low and after release, `rdValid`, `illegalPulse` and `pcRedirect` are 0. The vector base reads back as parameter `VECTOR_RESET`. Every other held register reads back 0.
- R2: Address 0x0014 (group 0, number 20, the floating-point status word) is open in both modes. A request to it raises `fpuSel` in the same cycle. A read of it returns `extRdata`, and no illegal pulse follows.
- R3: In user mode (`superMode`=0), a request to any address other than 0x0014 raises `illegalPulse` for exactly the following cycle. It raises no select strobe and no `rdValid`, and any write it carries leaves the addressed register unchanged.
- R4: In supervisor mode, the vector base (0x000B), exception PC (0x0020), effective address (0x0030) and exception status (0x0040) are written by a write and read back by a read.
- R5: Address 0x2801 holds accumulator bits 31:0 and 0x2802 holds bits 63:32. Writing one half leaves the other half unchanged.
- R6: Shadow register k (flat index = set*32 + register) sits at group 0, number 1024+k, for k below `SHADOW_SETS`*32. Numbers at or beyond that bound behave as unassigned.
- R7: A supervisor read of an unassigned address returns the `reqDest` value presented with the request.
- R8: Group 0 numbers 0 to 4, 9 and 10 read as {`CFG_TAG`, number[7:0]}. Writes to them change nothing.
- R9: Address 0x0010 reads as `curPc`. A supervisor write to it whose data differs from `curPc` pulses `pcRedirect` for one cycle with `pcTarget` equal to that data, and the core also clears its delay-slot flag on this pulse. A write equal to `curPc` produces no pulse.
- R10: In supervisor mode, groups 1 and 2 raise `mmuSel`, group 9 raises `picSel` and group 10 raises `timerSel` in the request cycle. Reads of these groups return `extRdata`.
- R11: `rdValid` pulses for one cycle, exactly one cycle after each permitted read request, and only then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| reqAddr | input | 16 | Register address {group[4:0], number[10:0]} |
| reqWdata | input | 32 | Write data |
| reqDest | input | 32 | Old destination register value |
| superMode | input | 1 | Supervisor flag of the status register |
| curPc | input | 32 | PC of the requesting instruction |
| extRdata | input | 32 | Read data from the external unit selected this cycle |
| fpuSel | output | 1 | Floating-point status word selected (combinational) |
| mmuSel | output | 1 | Translation arrays selected (combinational) |
| picSel | output | 1 | Interrupt controller selected (combinational) |
| timerSel | output | 1 | Tick timer selected (combinational) |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| illegalPulse | output | 1 | Illegal-instruction exception request |
| pcRedirect | output | 1 | Redirect fetch to pcTarget and clear the delay slot |
| pcTarget | output | 32 | Redirect target |

## Verification
The select strobes are combinational, so they are checked shortly after the request is driven, still inside the request cycle. Read data, the illegal pulse and the redirect are each registered once, so they are due one cycle after the request. The driver pushes one expected item for each such result. The monitor samples a quarter period after each rising edge and pops one item for every pulse it sees. An unexpected pulse therefore shows up as a pop from an empty queue, and a missing one leaves the queue non-empty at the end. Ignored writes are followed by a supervisor read, so their absence of effect is observed at the ports.

// File: rtl/sprPkg.sv
package sprPkg;
  typedef enum logic [3:0] {
    RD_DEST, RD_EXT, RD_CFG, RD_PC, RD_EVBAR, RD_EPCR,
    RD_EEAR, RD_ESR, RD_MACLO, RD_MACHI, RD_SHADOW
  } rdSelT;

  typedef struct packed {
    logic  wrEvbar;
    logic  wrEpcr;
    logic  wrEear;
    logic  wrEsr;
    logic  wrMacLo;
    logic  wrMacHi;
    logic  wrShadow;
    logic  rdEn;
    rdSelT rdSel;
  } sprStrobeT;

  localparam logic [4:0]  GRP_SYS   = 5'd0;
  localparam logic [4:0]  GRP_DMMU  = 5'd1;
  localparam logic [4:0]  GRP_IMMU  = 5'd2;
  localparam logic [4:0]  GRP_MAC   = 5'd5;
  localparam logic [4:0]  GRP_PIC   = 5'd9;
  localparam logic [4:0]  GRP_TICK  = 5'd10;
  localparam logic [10:0] NUM_FPU   = 11'd20;
  localparam logic [10:0] NUM_NPC   = 11'd16;
  localparam logic [10:0] NUM_VEC   = 11'd11;
  localparam logic [10:0] NUM_EPC   = 11'd32;
  localparam logic [10:0] NUM_EEA   = 11'd48;
  localparam logic [10:0] NUM_EST   = 11'd64;
  localparam logic [10:0] NUM_SHBASE = 11'd1024;
endpackage

// File: rtl/sprCtrl.sv
module sprCtrl
  import sprPkg::*;
#(
  parameter int SHADOW_SETS = 2,
  localparam int SH_COUNT = SHADOW_SETS * 32,
  localparam int SH_W = $clog2(SH_COUNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [15:0]     reqAddr,
  input  logic [31:0]     reqWdata,
  input  logic            superMode,
  input  logic [31:0]     curPc,
  output sprStrobeT       strb,
  output logic [SH_W-1:0] shadowIdx,
  output logic            fpuSel,
  output logic            mmuSel,
  output logic            picSel,
  output logic            timerSel,
  output logic            illegalPulse,
  output logic            pcRedirect,
  output logic [31:0]     pcTarget
);
  logic [4:0]  grp;
  logic [10:0] num;
  logic        isFpu, allowed, go, npcHit, inShadow;
  rdSelT       sel;
  logic        hitVec, hitEpc, hitEea, hitEst, hitLo, hitHi;

  assign grp      = reqAddr[15:11];
  assign num      = reqAddr[10:0];
  assign isFpu    = (grp == GRP_SYS) && (num == NUM_FPU);
  assign allowed  = isFpu || superMode;
  assign go       = reqValid && allowed;
  assign inShadow = ({1'b0, num} >= {1'b0, NUM_SHBASE}) &&
                    ({1'b0, num} < 12'(1024 + SH_COUNT));
  assign shadowIdx = num[SH_W-1:0];

  always_comb begin
    sel = RD_DEST;
    {fpuSel, mmuSel, picSel, timerSel} = '0;
    {hitVec, hitEpc, hitEea, hitEst, hitLo, hitHi, npcHit} = '0;
    if (go) begin
      unique case (grp)
        GRP_SYS: begin
          if (num == NUM_FPU) begin fpuSel = 1'b1; sel = RD_EXT; end
          else if (num <= 11'd4 || num == 11'd9 || num == 11'd10) sel = RD_CFG;
          else if (num == NUM_VEC) begin hitVec = 1'b1; sel = RD_EVBAR; end
          else if (num == NUM_NPC) begin npcHit = 1'b1; sel = RD_PC; end
          else if (num == NUM_EPC) begin hitEpc = 1'b1; sel = RD_EPCR; end
          else if (num == NUM_EEA) begin hitEea = 1'b1; sel = RD_EEAR; end
          else if (num == NUM_EST) begin hitEst = 1'b1; sel = RD_ESR; end
          else if (inShadow) sel = RD_SHADOW;
        end
        GRP_DMMU, GRP_IMMU: begin mmuSel = 1'b1; sel = RD_EXT; end
        GRP_MAC: begin
          if (num == 11'd1) begin hitLo = 1'b1; sel = RD_MACLO; end
          else if (num == 11'd2) begin hitHi = 1'b1; sel = RD_MACHI; end
        end
        GRP_PIC:  begin picSel = 1'b1; sel = RD_EXT; end
        GRP_TICK: begin timerSel = 1'b1; sel = RD_EXT; end
        default: ;
      endcase
    end
    strb.rdSel    = sel;
    strb.rdEn     = go && !reqWrite;
    strb.wrEvbar  = reqWrite && hitVec;
    strb.wrEpcr   = reqWrite && hitEpc;
    strb.wrEear   = reqWrite && hitEea;
    strb.wrEsr    = reqWrite && hitEst;
    strb.wrMacLo  = reqWrite && hitLo;
    strb.wrMacHi  = reqWrite && hitHi;
    strb.wrShadow = reqWrite && (sel == RD_SHADOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      illegalPulse <= 1'b0;
      pcRedirect   <= 1'b0;
      pcTarget     <= '0;
    end else begin
      illegalPulse <= reqValid && !allowed;
      pcRedirect   <= reqWrite && npcHit && (reqWdata != curPc);
      if (reqWrite && npcHit && (reqWdata != curPc)) pcTarget <= reqWdata;
    end
  end
endmodule

// File: rtl/sprDatapath.sv
module sprDatapath
  import sprPkg::*;
#(
  parameter int          SHADOW_SETS  = 2,
  parameter logic [31:0] VECTOR_RESET = 32'h0000_0100,
  parameter logic [23:0] CFG_TAG      = 24'h12_0A00,
  localparam int SH_COUNT = SHADOW_SETS * 32,
  localparam int SH_W = $clog2(SH_COUNT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  sprStrobeT       strb,
  input  logic [SH_W-1:0] shadowIdx,
  input  logic [7:0]      cfgNum,
  input  logic [31:0]     reqWdata,
  input  logic [31:0]     reqDest,
  input  logic [31:0]     curPc,
  input  logic [31:0]     extRdata,
  output logic            rdValid,
  output logic [31:0]     rdData
);
  logic [31:0] vecBase, excPc, excAddr, excStat;
  logic [63:0] macAcc;
  logic [31:0] shadowMem [SH_COUNT];
  logic [31:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecBase <= VECTOR_RESET;
      excPc   <= '0;
      excAddr <= '0;
      excStat <= '0;
      macAcc  <= '0;
      for (int i = 0; i < SH_COUNT; i++) shadowMem[i] <= '0;
    end else begin
      if (strb.wrEvbar)  vecBase <= reqWdata;
      if (strb.wrEpcr)   excPc   <= reqWdata;
      if (strb.wrEear)   excAddr <= reqWdata;
      if (strb.wrEsr)    excStat <= reqWdata;
      if (strb.wrMacLo)  macAcc[31:0]  <= reqWdata;
      if (strb.wrMacHi)  macAcc[63:32] <= reqWdata;
      if (strb.wrShadow) shadowMem[shadowIdx] <= reqWdata;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_EXT:    rdNext = extRdata;
      RD_CFG:    rdNext = {CFG_TAG, cfgNum};
      RD_PC:     rdNext = curPc;
      RD_EVBAR:  rdNext = vecBase;
      RD_EPCR:   rdNext = excPc;
      RD_EEAR:   rdNext = excAddr;
      RD_ESR:    rdNext = excStat;
      RD_MACLO:  rdNext = macAcc[31:0];
      RD_MACHI:  rdNext = macAcc[63:32];
      RD_SHADOW: rdNext = shadowMem[shadowIdx];
      default:   rdNext = reqDest;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/sprAccessUnit.sv
module sprAccessUnit
  import sprPkg::*;
#(
  parameter int          SHADOW_SETS  = 2,
  parameter logic [31:0] VECTOR_RESET = 32'h0000_0100,
  parameter logic [23:0] CFG_TAG      = 24'h12_0A00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [31:0] reqWdata,
  input  logic [31:0] reqDest,
  input  logic        superMode,
  input  logic [31:0] curPc,
  input  logic [31:0] extRdata,
  output logic        fpuSel,
  output logic        mmuSel,
  output logic        picSel,
  output logic        timerSel,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        illegalPulse,
  output logic        pcRedirect,
  output logic [31:0] pcTarget
);
  localparam int SH_W = $clog2(SHADOW_SETS * 32);

  sprStrobeT       strb;
  logic [SH_W-1:0] shadowIdx;

  sprCtrl #(.SHADOW_SETS(SHADOW_SETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .superMode(superMode),
    .curPc(curPc), .strb(strb), .shadowIdx(shadowIdx),
    .fpuSel(fpuSel), .mmuSel(mmuSel), .picSel(picSel), .timerSel(timerSel),
    .illegalPulse(illegalPulse), .pcRedirect(pcRedirect), .pcTarget(pcTarget)
  );

  sprDatapath #(
    .SHADOW_SETS(SHADOW_SETS), .VECTOR_RESET(VECTOR_RESET), .CFG_TAG(CFG_TAG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .shadowIdx(shadowIdx),
    .cfgNum(reqAddr[7:0]), .reqWdata(reqWdata), .reqDest(reqDest),
    .curPc(curPc), .extRdata(extRdata), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/sprAccessChecker.sv
module sprAccessChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [15:0] reqAddr,
  input logic [31:0] reqWdata,
  input logic        superMode,
  input logic [31:0] curPc,
  input logic        mmuSel,
  input logic        picSel,
  input logic        timerSel,
  input logic        rdValid,
  input logic        illegalPulse,
  input logic        pcRedirect
);
  AST_ILLEGAL_FROM_USER: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> $past(reqValid && !superMode && reqAddr != 16'h0014)); // R3
  AST_NO_DATA_ON_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> !rdValid); // R3
  AST_USER_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !superMode) |-> !(mmuSel || picSel || timerSel)); // R3
  AST_RDVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(reqValid && !reqWrite)); // R11
  AST_REDIRECT_CHANGES_PC: assert property (@(posedge clk) disable iff (!rstN)
    pcRedirect |-> $past(reqValid && reqWrite && superMode && reqWdata != curPc)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mmuSel, picSel, timerSel})); // R10
endmodule

bind sprAccessUnit sprAccessChecker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqWdata(reqWdata), .superMode(superMode),
  .curPc(curPc), .mmuSel(mmuSel), .picSel(picSel), .timerSel(timerSel),
  .rdValid(rdValid), .illegalPulse(illegalPulse), .pcRedirect(pcRedirect)
);

// File: tb/sprAccessUnit_bench.sv
module sprAccessUnit_bench;
  localparam logic [31:0] VEC_RST = 32'h0000_0100;
  localparam logic [23:0] TAG     = 24'h12_0A00;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, superMode = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0, reqDest = '0, curPc = 32'h100, extRdata = '0;
  logic fpuSel, mmuSel, picSel, timerSel, rdValid, illegalPulse, pcRedirect;
  logic [31:0] rdData, pcTarget;

  int checks = 0, errors = 0;

  typedef struct { int kind; logic [31:0] data; string tag; } expT;
  expT sb[$];

  always #10 clk = ~clk;

  sprAccessUnit #(.SHADOW_SETS(2), .VECTOR_RESET(VEC_RST), .CFG_TAG(TAG)) u_sprAccessUnit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDest(reqDest),
    .superMode(superMode), .curPc(curPc), .extRdata(extRdata),
    .fpuSel(fpuSel), .mmuSel(mmuSel), .picSel(picSel), .timerSel(timerSel),
    .rdValid(rdValid), .rdData(rdData), .illegalPulse(illegalPulse),
    .pcRedirect(pcRedirect), .pcTarget(pcTarget)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // kind: 0 no result, 1 read data, 2 illegal, 3 redirect; sel = {fpu,mmu,pic,timer}
  task automatic issue(input bit wr, input logic [15:0] addr, input logic [31:0] wd,
                       input logic [31:0] dest, input bit sup, input int kind,
                       input logic [31:0] expData, input logic [3:0] sel, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    reqDest = dest; superMode = sup;
    if (kind != 0) sb.push_back('{kind, expData, tag});
    #1;
    check({fpuSel, mmuSel, picSel, timerSel} == sel, tag,
          {28'd0, fpuSel, mmuSel, picSel, timerSel}, {28'd0, sel});
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (rstN && (rdValid || illegalPulse || pcRedirect)) begin
        int actKind;
        logic [31:0] actData;
        actKind = rdValid ? 1 : (illegalPulse ? 2 : 3);
        actData = rdValid ? rdData : (pcRedirect ? pcTarget : 32'd0);
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected result", actData, 32'd0);
        end else begin
          expT e;
          e = sb.pop_front();
          check(actKind == e.kind, e.tag, 32'(actKind), 32'(e.kind));
          if (e.kind != 2) check(actData == e.data, e.tag, actData, e.data);
        end
      end
    end
  end

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(20 * 20000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!rdValid && !illegalPulse && !pcRedirect, "R1 outputs in reset",
          {29'd0, rdValid, illegalPulse, pcRedirect}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!rdValid && !illegalPulse && !pcRedirect, "R1 outputs after reset",
          {29'd0, rdValid, illegalPulse, pcRedirect}, 32'd0);
    issue(0, 16'h000B, 0, 0, 1, 1, VEC_RST, 4'b0000, "R1 vector base reset");
    issue(0, 16'h2802, 0, 0, 1, 1, 32'd0, 4'b0000, "R1 accumulator reset");

    extRdata = 32'h0000_F00D;
    issue(0, 16'h0014, 0, 0, 0, 1, 32'h0000_F00D, 4'b1000, "R2 user read fp status");
    issue(1, 16'h0014, 32'h3, 0, 0, 0, 0, 4'b1000, "R2 user write fp status");

    issue(0, 16'h0020, 0, 0, 0, 2, 0, 4'b0000, "R3 user read exception PC");
    issue(1, 16'h0020, 32'h1234, 0, 0, 2, 0, 4'b0000, "R3 user write exception PC");
    issue(0, 16'h0020, 0, 0, 1, 1, 32'd0, 4'b0000, "R3 write ignored");
    issue(0, 16'h4800, 0, 0, 0, 2, 0, 4'b0000, "R3 user interrupt controller");

    issue(1, 16'h000B, 32'h0000_2000, 0, 1, 0, 0, 4'b0000, "R4 write vector");
    issue(1, 16'h0020, 32'hAAAA_0001, 0, 1, 0, 0, 4'b0000, "R4 write epc");
    issue(1, 16'h0030, 32'hBBBB_0002, 0, 1, 0, 0, 4'b0000, "R4 write eea");
    issue(1, 16'h0040, 32'hCCCC_0003, 0, 1, 0, 0, 4'b0000, "R4 write esr");
    issue(0, 16'h000B, 0, 0, 1, 1, 32'h0000_2000, 4'b0000, "R4 read vector");
    issue(0, 16'h0020, 0, 0, 1, 1, 32'hAAAA_0001, 4'b0000, "R4 read epc");
    issue(0, 16'h0030, 0, 0, 1, 1, 32'hBBBB_0002, 4'b0000, "R4 read eea");
    issue(0, 16'h0040, 0, 0, 1, 1, 32'hCCCC_0003, 4'b0000, "R4 read esr");

    issue(1, 16'h2801, 32'h1111_1111, 0, 1, 0, 0, 4'b0000, "R5 write low");
    issue(1, 16'h2802, 32'h2222_2222, 0, 1, 0, 0, 4'b0000, "R5 write high");
    issue(1, 16'h2801, 32'h3333_3333, 0, 1, 0, 0, 4'b0000, "R5 rewrite low");
    issue(0, 16'h2802, 0, 0, 1, 1, 32'h2222_2222, 4'b0000, "R5 high kept");
    issue(0, 16'h2801, 0, 0, 1, 1, 32'h3333_3333, 4'b0000, "R5 low updated");

    issue(1, 16'h0425, 32'h5151_0037, 0, 1, 0, 0, 4'b0000, "R6 write set1 reg5");
    issue(1, 16'h0405, 32'h5050_0005, 0, 1, 0, 0, 4'b0000, "R6 write set0 reg5");
    issue(0, 16'h0425, 0, 0, 1, 1, 32'h5151_0037, 4'b0000, "R6 read set1 reg5");
    issue(0, 16'h0405, 0, 0, 1, 1, 32'h5050_0005, 4'b0000, "R6 read set0 reg5");
    issue(1, 16'h0440, 32'hDEAD, 0, 1, 0, 0, 4'b0000, "R6 write past bank");
    issue(0, 16'h0440, 0, 32'h77, 1, 1, 32'h77, 4'b0000, "R6 read past bank");

    issue(0, 16'h0011, 0, 32'hABCD, 1, 1, 32'hABCD, 4'b0000, "R7 unassigned sys");
    issue(0, 16'h1800, 0, 32'h9999, 1, 1, 32'h9999, 4'b0000, "R7 unassigned group");

    issue(0, 16'h0009, 0, 0, 1, 1, {TAG, 8'd9}, 4'b0000, "R8 config read");
    issue(1, 16'h0002, 32'hFFFF_FFFF, 0, 1, 0, 0, 4'b0000, "R8 config write");
    issue(0, 16'h0002, 0, 0, 1, 1, {TAG, 8'd2}, 4'b0000, "R8 config unchanged");

    issue(0, 16'h0010, 0, 0, 1, 1, 32'h100, 4'b0000, "R9 read next PC");
    issue(1, 16'h0010, 32'h100, 0, 1, 0, 0, 4'b0000, "R9 same PC no redirect");
    issue(1, 16'h0010, 32'h200, 0, 1, 3, 32'h200, 4'b0000, "R9 redirect");

    extRdata = 32'h0000_0E11;
    issue(0, 16'h0A58, 0, 0, 1, 1, 32'h0E11, 4'b0100, "R10 data translation");
    issue(1, 16'h1200, 32'h1, 0, 1, 0, 0, 4'b0100, "R10 instr translation");
    issue(0, 16'h4800, 0, 0, 1, 1, 32'h0E11, 4'b0010, "R10 interrupt ctl");
    issue(0, 16'h5001, 0, 0, 1, 1, 32'h0E11, 4'b0001, "R10 tick timer");

    // back-to-back reads: two pulses, one per request
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; superMode = 1'b1; reqAddr = 16'h0040;
    sb.push_back('{1, 32'hCCCC_0003, "R11 back-to-back first"});
    @(negedge clk);
    reqAddr = 16'h0030;
    sb.push_back('{1, 32'hBBBB_0002, "R11 back-to-back second"});
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R11 all results delivered", 32'(sb.size()), 32'd0);
    finishRun();
  end
endmodule